// File: doc/BRIEF.md
# Shared Address/Data Bus Splitter

This block connects a processor whose low address byte and data byte share eight pins to a system bus that expects a separate, stable address and separate command lines. While the processor holds its address-latch-enable input high, the shared lines carry the low address byte, and the block captures that byte into a register. When the enable falls, the register holds the byte through the data phase. The twelve upper address bits pass straight through. Together these form a 20-bit system address.

The processor presents one active-low read strobe, one active-low write strobe and a select line that is low for memory and high for I/O. The block turns these into four separate active-low commands: memory read, memory write, I/O read and I/O write. It also steers the data byte. Read data from the system is presented toward the processor only while a read is in progress. Write data is enabled toward the system only while a write is in progress and the address phase has ended. If read and write are both low at once, the block raises a conflict flag and asserts no command.

With the default `CTRL_REG = 1`, every control output is registered, so it follows the inputs sampled at the preceding rising clock edge. With `CTRL_REG = 0`, the control outputs are combinational.

Top module: `adbus_demux`

## Requirements
- R1: While reset is held, all four command outputs are high, the write-enable, direction and conflict outputs are low, and the low address byte reads zero.
- R2: On a rising clock edge where the enable input is high, the low address register takes the value on the shared lines. From that edge on, the value appears on `sys_addr_o[7:0]`.
- R3: On a rising clock edge where the enable input is low, the low address byte keeps its previous value, however the shared lines change.
- R4: `sys_addr_o[19:8]` always equals `cpu_ahi_i`, with no clock delay.
- R5: The read commands follow from the sample at the preceding edge. `mem_rd_n_o` is low exactly when read was low, write was high and the select was 0. `io_rd_n_o` is low under the same condition with the select at 1.
- R6: The write commands follow the same rule with the roles of read and write swapped: `mem_wr_n_o` for a select of 0, `io_wr_n_o` for a select of 1.
- R7: At most one of the four command outputs is low at any time.
- R8: If read and write were both low at the sampling edge, all four commands are high and `rw_conflict_o` is high. Otherwise `rw_conflict_o` is low.
- R9: `dir_to_cpu_o` is high exactly when read was low at the sampling edge. `cpu_rdata_o` equals `sys_rdata_i` while the direction is high and is zero otherwise.
- R10: `sys_wdata_oe_o` is high exactly when write was low and the enable was low at the sampling edge. `sys_wdata_o` always equals the shared lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| cpu_ad_i | input | 8 | Shared lines from the processor: low address byte or write data |
| cpu_ahi_i | input | 12 | Upper address bits 8 to 19 |
| cpu_ale_i | input | 1 | Address phase marker, active high |
| cpu_rd_n_i | input | 1 | Read strobe, active low |
| cpu_wr_n_i | input | 1 | Write strobe, active low |
| cpu_io_sel_i | input | 1 | Access space: 0 selects memory, 1 selects I/O |
| sys_rdata_i | input | 8 | Read data from the system bus |
| sys_addr_o | output | 20 | Assembled system address |
| sys_wdata_o | output | 8 | Write data toward the system |
| sys_wdata_oe_o | output | 1 | Write data output enable |
| cpu_rdata_o | output | 8 | Read data toward the processor, zero when not reading |
| dir_to_cpu_o | output | 1 | Data direction: high means toward the processor |
| mem_rd_n_o | output | 1 | Memory read command, active low |
| mem_wr_n_o | output | 1 | Memory write command, active low |
| io_rd_n_o | output | 1 | I/O read command, active low |
| io_wr_n_o | output | 1 | I/O write command, active low |
| rw_conflict_o | output | 1 | High when read and write were both low |

## Verification
Two functions can fall in the same cycle. The first pair is address capture and the write path. The bench asserts write while the enable is still high, and then checks two things: the shared byte lands in the address register, and write data stays disabled. The second pair is the read and write decodes. Driving both strobes low together must raise the conflict flag and suppress every command. The bench sweeps all sixteen combinations of enable, read, write and select under several byte patterns, and computes each expected output arithmetically from the sampled inputs.

// File: rtl/adbus_pkg.sv
`timescale 1ns/1ps
package adbus_pkg;

   typedef struct packed {
      logic mem_rd_n;
      logic mem_wr_n;
      logic io_rd_n;
      logic io_wr_n;
   } cmd_t;

   localparam cmd_t CMD_IDLE = '{mem_rd_n: 1'b1, mem_wr_n: 1'b1, io_rd_n: 1'b1, io_wr_n: 1'b1};

   function automatic cmd_t decode_cmd(input logic rd_n, input logic wr_n, input logic io_sel);
      cmd_t c;
      logic rd_only;
      logic wr_only;
      rd_only    = !rd_n && wr_n;
      wr_only    = !wr_n && rd_n;
      c.mem_rd_n = !(rd_only && !io_sel);
      c.io_rd_n  = !(rd_only &&  io_sel);
      c.mem_wr_n = !(wr_only && !io_sel);
      c.io_wr_n  = !(wr_only &&  io_sel);
      return c;
   endfunction

endpackage

// File: rtl/adbus_addr_latch.sv
`timescale 1ns/1ps
module adbus_addr_latch #(
   parameter int AD_W = 8,
   parameter int HI_W = 12,
   localparam int ADDR_W = AD_W + HI_W
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              ale_i,
   input  logic [AD_W-1:0]   ad_i,
   input  logic [HI_W-1:0]   ahi_i,
   output logic [ADDR_W-1:0] addr_o
);

   initial begin
      if (AD_W < 1 || HI_W < 1) $error("adbus_addr_latch: widths must be positive");
   end

   logic [AD_W-1:0] lo_q;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i)   lo_q <= '0;
      else if (ale_i) lo_q <= ad_i;
   end

   assign addr_o = {ahi_i, lo_q};

   // R2
   capture_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ale_i |=> (addr_o[AD_W-1:0] == $past(ad_i)));

   // R3
   hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !ale_i |=> $stable(addr_o[AD_W-1:0]));

endmodule

// File: rtl/adbus_cmd_decode.sv
`timescale 1ns/1ps
module adbus_cmd_decode
   import adbus_pkg::*;
#(
   parameter bit CTRL_REG = 1'b1
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic rd_n_i,
   input  logic wr_n_i,
   input  logic io_sel_i,
   output cmd_t cmd_o,
   output logic conflict_o
);

   cmd_t cmd_d;
   logic conflict_d;

   always_comb begin
      cmd_d      = decode_cmd(rd_n_i, wr_n_i, io_sel_i);
      conflict_d = !rd_n_i && !wr_n_i;
   end

   generate
      if (CTRL_REG) begin : g_reg
         cmd_t cmd_q;
         logic conflict_q;
         always_ff @(posedge clk_i) begin
            if (!rst_n_i) begin
               cmd_q      <= CMD_IDLE;
               conflict_q <= 1'b0;
            end else begin
               cmd_q      <= cmd_d;
               conflict_q <= conflict_d;
            end
         end
         assign cmd_o      = cmd_q;
         assign conflict_o = conflict_q;

         // R8
         conflict_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (!rd_n_i && !wr_n_i) |=> (conflict_o && (cmd_o == CMD_IDLE)));
      end else begin : g_comb
         assign cmd_o      = rst_n_i ? cmd_d : CMD_IDLE;
         assign conflict_o = rst_n_i && conflict_d;

         // R8
         conflict_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (!rd_n_i && !wr_n_i) |-> (conflict_o && (cmd_o == CMD_IDLE)));
      end
   endgenerate

   // R7
   one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $countones(~cmd_o) <= 1);

endmodule

// File: rtl/adbus_data_route.sv
`timescale 1ns/1ps
module adbus_data_route #(
   parameter int AD_W     = 8,
   parameter bit CTRL_REG = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_n_i,
   input  logic            ale_i,
   input  logic            rd_n_i,
   input  logic            wr_n_i,
   input  logic [AD_W-1:0] ad_i,
   input  logic [AD_W-1:0] sys_rdata_i,
   output logic [AD_W-1:0] wdata_o,
   output logic            wdata_oe_o,
   output logic [AD_W-1:0] rdata_o,
   output logic            dir_o
);

   logic dir_d;
   logic oe_d;

   assign dir_d = !rd_n_i;
   assign oe_d  = !wr_n_i && !ale_i;

   generate
      if (CTRL_REG) begin : g_reg
         logic dir_q;
         logic oe_q;
         always_ff @(posedge clk_i) begin
            if (!rst_n_i) begin
               dir_q <= 1'b0;
               oe_q  <= 1'b0;
            end else begin
               dir_q <= dir_d;
               oe_q  <= oe_d;
            end
         end
         assign dir_o      = dir_q;
         assign wdata_oe_o = oe_q;

         // R10
         ale_blocks_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            ale_i |=> !wdata_oe_o);
      end else begin : g_comb
         assign dir_o      = rst_n_i && dir_d;
         assign wdata_oe_o = rst_n_i && oe_d;

         // R10
         ale_blocks_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            ale_i |-> !wdata_oe_o);
      end
   endgenerate

   assign wdata_o = ad_i;
   assign rdata_o = dir_o ? sys_rdata_i : '0;

endmodule

// File: rtl/adbus_demux.sv
`timescale 1ns/1ps
module adbus_demux
   import adbus_pkg::*;
#(
   parameter int AD_W     = 8,
   parameter int HI_W     = 12,
   parameter bit CTRL_REG = 1'b1,
   localparam int ADDR_W  = AD_W + HI_W
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic [AD_W-1:0]   cpu_ad_i,
   input  logic [HI_W-1:0]   cpu_ahi_i,
   input  logic              cpu_ale_i,
   input  logic              cpu_rd_n_i,
   input  logic              cpu_wr_n_i,
   input  logic              cpu_io_sel_i,
   input  logic [AD_W-1:0]   sys_rdata_i,
   output logic [ADDR_W-1:0] sys_addr_o,
   output logic [AD_W-1:0]   sys_wdata_o,
   output logic              sys_wdata_oe_o,
   output logic [AD_W-1:0]   cpu_rdata_o,
   output logic              dir_to_cpu_o,
   output logic              mem_rd_n_o,
   output logic              mem_wr_n_o,
   output logic              io_rd_n_o,
   output logic              io_wr_n_o,
   output logic              rw_conflict_o
);

   cmd_t cmd;

   adbus_addr_latch #(.AD_W(AD_W), .HI_W(HI_W)) addr_i (
      .clk_i  (clk_i),
      .rst_n_i(rst_n_i),
      .ale_i  (cpu_ale_i),
      .ad_i   (cpu_ad_i),
      .ahi_i  (cpu_ahi_i),
      .addr_o (sys_addr_o)
   );

   adbus_cmd_decode #(.CTRL_REG(CTRL_REG)) dec_i (
      .clk_i     (clk_i),
      .rst_n_i   (rst_n_i),
      .rd_n_i    (cpu_rd_n_i),
      .wr_n_i    (cpu_wr_n_i),
      .io_sel_i  (cpu_io_sel_i),
      .cmd_o     (cmd),
      .conflict_o(rw_conflict_o)
   );

   adbus_data_route #(.AD_W(AD_W), .CTRL_REG(CTRL_REG)) route_i (
      .clk_i      (clk_i),
      .rst_n_i    (rst_n_i),
      .ale_i      (cpu_ale_i),
      .rd_n_i     (cpu_rd_n_i),
      .wr_n_i     (cpu_wr_n_i),
      .ad_i       (cpu_ad_i),
      .sys_rdata_i(sys_rdata_i),
      .wdata_o    (sys_wdata_o),
      .wdata_oe_o (sys_wdata_oe_o),
      .rdata_o    (cpu_rdata_o),
      .dir_o      (dir_to_cpu_o)
   );

   assign mem_rd_n_o = cmd.mem_rd_n;
   assign mem_wr_n_o = cmd.mem_wr_n;
   assign io_rd_n_o  = cmd.io_rd_n;
   assign io_wr_n_o  = cmd.io_wr_n;

   // R4
   upper_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      sys_addr_o[ADDR_W-1:AD_W] == cpu_ahi_i);

endmodule

// File: tb/adbus_demux_tb_top.sv
`timescale 1ns/1ps
module adbus_demux_tb_top;

   localparam int AD_W = 8;
   localparam int HI_W = 12;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [AD_W-1:0] ad = '0;
   logic [HI_W-1:0] ahi = '0;
   logic            ale = 1'b0;
   logic            rd_n = 1'b1;
   logic            wr_n = 1'b1;
   logic            io_sel = 1'b0;
   logic [AD_W-1:0] rdata_in = '0;

   logic [AD_W+HI_W-1:0] addr;
   logic [AD_W-1:0]      wdata;
   logic                 oe;
   logic [AD_W-1:0]      rdata_out;
   logic                 dir;
   logic                 mrd_n, mwr_n, iord_n, iowr_n, conf;

   int checks = 0;
   int errors = 0;
   logic [AD_W-1:0] exp_lo = '0;

   always #2.5 clk = ~clk;

   adbus_demux dut_i (
      .clk_i(clk), .rst_n_i(rst_n), .cpu_ad_i(ad), .cpu_ahi_i(ahi),
      .cpu_ale_i(ale), .cpu_rd_n_i(rd_n), .cpu_wr_n_i(wr_n),
      .cpu_io_sel_i(io_sel), .sys_rdata_i(rdata_in),
      .sys_addr_o(addr), .sys_wdata_o(wdata), .sys_wdata_oe_o(oe),
      .cpu_rdata_o(rdata_out), .dir_to_cpu_o(dir),
      .mem_rd_n_o(mrd_n), .mem_wr_n_o(mwr_n), .io_rd_n_o(iord_n),
      .io_wr_n_o(iowr_n), .rw_conflict_o(conf)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input logic a, input logic r, input logic w, input logic s,
                       input logic [AD_W-1:0] d, input logic [HI_W-1:0] h,
                       input logic [AD_W-1:0] sd);
      logic rd_only, wr_only;
      @(negedge clk);
      ale = a; rd_n = r; wr_n = w; io_sel = s; ad = d; ahi = h; rdata_in = sd;
      #1;
      chk("R4 upper address", {20'd0, addr[AD_W+HI_W-1:AD_W]}, {20'd0, h});
      @(posedge clk);
      #1;
      if (a) exp_lo = d;
      rd_only = !r && w;
      wr_only = !w && r;
      chk("R2/R3 low address", {24'd0, addr[AD_W-1:0]}, {24'd0, exp_lo});
      chk("R5 mem read", {31'd0, mrd_n}, {31'd0, !(rd_only && !s)});
      chk("R5 io read", {31'd0, iord_n}, {31'd0, !(rd_only && s)});
      chk("R6 mem write", {31'd0, mwr_n}, {31'd0, !(wr_only && !s)});
      chk("R6 io write", {31'd0, iowr_n}, {31'd0, !(wr_only && s)});
      chk("R7 strobe count", $countones({mrd_n, mwr_n, iord_n, iowr_n}) >= 3, 32'd1);
      chk("R8 conflict", {31'd0, conf}, {31'd0, (!r && !w)});
      chk("R9 direction", {31'd0, dir}, {31'd0, !r});
      chk("R9 read data", {24'd0, rdata_out}, {24'd0, (!r ? sd : 8'd0)});
      chk("R10 write enable", {31'd0, oe}, {31'd0, (!w && !a)});
      chk("R10 write data", {24'd0, wdata}, {24'd0, d});
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      ad = 8'hA5; ale = 1'b1; rd_n = 1'b0; wr_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 mem read", {31'd0, mrd_n}, 32'd1);
      chk("R1 mem write", {31'd0, mwr_n}, 32'd1);
      chk("R1 io read", {31'd0, iord_n}, 32'd1);
      chk("R1 io write", {31'd0, iowr_n}, 32'd1);
      chk("R1 oe", {31'd0, oe}, 32'd0);
      chk("R1 dir", {31'd0, dir}, 32'd0);
      chk("R1 conflict", {31'd0, conf}, 32'd0);
      chk("R1 low address", {24'd0, addr[7:0]}, 32'd0);
      @(negedge clk);
      ale = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
      rst_n = 1'b1;
      exp_lo = '0;
      // exhaustive sweep: enable, read, write, select, under several byte patterns
      for (int p = 0; p < 6; p++) begin
         for (int c = 0; c < 16; c++) begin
            int k;
            k = p * 16 + c;
            step(c[3], c[2], c[1], c[0],
                 AD_W'((k * 73 + 11) & 8'hFF),
                 HI_W'((k * 37 + 5) & 12'hFFF),
                 AD_W'(~((k * 29 + 3) & 8'hFF)));
         end
      end
      // R3: shared lines toggle in the data phase, low byte must hold
      step(1'b1, 1'b1, 1'b1, 1'b0, 8'h3C, 12'h123, 8'h00);
      for (int i = 0; i < 8; i++) begin
         step(1'b0, 1'b1, 1'b0, i[0], AD_W'(8'h01 << i), 12'hABC, 8'h55);
      end
      // R10/R2: write asserted during the address phase
      step(1'b1, 1'b1, 1'b0, 1'b0, 8'hE7, 12'hFFF, 8'h11);
      step(1'b0, 1'b1, 1'b0, 1'b0, 8'h42, 12'hFFF, 8'h11);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule